// File: doc/BRIEF.md
# Watchdog Timer with Timed Unlock

The block is a watchdog for a system controller. It counts ticks from a free-running watchdog oscillator that runs on its own clock. If software does not kick it before the selected timeout expires, it raises a one-cycle reset request. An 8-bit control register holds three fields: an unlock (change-enable) bit, an enable bit and a 3-bit prescaler select. Two strap inputs are sampled while reset is held. They select a safety level, and the level decides three things: whether the watchdog starts running, whether it can ever be stopped, and whether the prescaler is write-protected.

Protected changes use a short unlock window. Software writes the unlock bit, and the window stays open for a fixed number of register-clock cycles, then closes by itself. Inside the window the enable bit may be cleared and, at the protected levels, the prescaler may be reloaded. The oscillator tick is resynchronised and edge-detected before it reaches the counter.

Two small state machines carry the behaviour:
- **Unlock machine.** States `UNL_LOCKED` and `UNL_OPEN`. An arm write moves LOCKED to OPEN. A further arm write while OPEN reloads the window. When the window count runs out, OPEN returns to LOCKED.
- **Count machine.** States `CT_IDLE`, `CT_COUNT` and `CT_FIRE`.
  - IDLE moves to COUNT once the watchdog is enabled.
  - COUNT moves to FIRE on a tick that completes the period.
  - FIRE goes back to COUNT on the next cycle.
  - COUNT or FIRE returns to IDLE when the watchdog is disabled.

Top module: `wdog_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, `ctl_rd_o` reads 0x00, or 0x08 at safety level 2, and `wdt_req_o` is low.
- R2: Bits 7..5 of `ctl_rd_o` always read zero, whatever value is written to them.
- R3: A write with bit 4 set makes bit 4 read one for exactly 4 cycles after the write. After that it clears by itself. Writing bit 4 again while it is still one restarts the 4-cycle window.
- R4: At levels 0 and 1, a write with bit 3 set makes bit 3 read one from the next cycle on.
- R5: A write with bit 3 clear turns the watchdog off only if bit 4 reads one in the cycle of that write. Otherwise bit 3 keeps its value.
- R6: Bits 2..0 take the written value at every write at level 0. At levels 1 and 2 they take it only when bit 4 reads one in the cycle of the write; otherwise they keep their value.
- R7: The level is latched from `cfg_a_i`/`cfg_b_i` during reset, as follows:

  | `cfg_a_i` | `cfg_b_i` | Level |
  |---|---|---|
  | 0 | 0 | 1 |
  | 0 | 1 | 2 |
  | 1 | 0 | 0 |
  | 1 | 1 | 2 |

- R8: At level 2, bit 3 always reads one and no write can turn the watchdog off.
- R9: While enabled, rising tick edges are counted. When 2^(BASE_EXP+bits 2..0) edges have been counted without a kick, `wdt_req_o` goes high for exactly one cycle and the count restarts from zero.
- R10: `kick_i` clears the count, and a kick takes priority over a tick edge in the same cycle. While the watchdog is disabled the count stays at zero and no request is raised.
- R11: `tick_i` passes through a two-flop synchroniser and an edge detector, so each rising edge counts once however long the tick stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| cfg_a_i | input | 1 | Safety strap A |
| cfg_b_i | input | 1 | Safety strap B |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wd_i | input | 8 | Control register write data |
| ctl_rd_o | output | 8 | Control register read data |
| kick_i | input | 1 | Restart pulse for the counter |
| tick_i | input | 1 | Watchdog oscillator tick, asynchronous |
| wdt_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
Each of the four strap combinations is reset into, and the same write pattern is applied at each one. The pattern contains three kinds of write:
- a plain clear of the enable bit;
- a plain prescaler write;
- the same two writes inside an open unlock window.

This separates the three safety levels by which writes stick. A re-arm written part-way through a window tells a self-restarting window apart from a fixed one. On the counting side, short tick pulses are mixed with ones held high for many cycles, which shows that level-held ticks do not count repeatedly. A kick placed just before the period would end shows that the count restarts rather than pauses.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CTL_W    = 8;
    localparam int PS_W     = 3;
    localparam int CE_POS   = 4;
    localparam int EN_POS   = 3;
    localparam int RESV_W   = CTL_W - CE_POS - 1;

    typedef enum logic [1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2
    } safety_lvl_e;

    typedef enum logic {
        UNL_LOCKED = 1'b0,
        UNL_OPEN   = 1'b1
    } unl_state_e;

    typedef enum logic [1:0] {
        CT_IDLE  = 2'd0,
        CT_COUNT = 2'd1,
        CT_FIRE  = 2'd2
    } cnt_state_e;

    typedef struct packed {
        logic            arm;
        logic            en_set;
        logic            en_clr;
        logic            ps_load;
        logic [PS_W-1:0] ps_val;
    } ctl_cmd_t;

    // Strap B dominates: it always forces the locked-on level.
    function automatic safety_lvl_e strap_level(input logic sel_a, input logic sel_b);
        if (sel_b)
            return LVL_2;
        else if (sel_a)
            return LVL_0;
        else
            return LVL_1;
    endfunction

endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async_i,
    output logic tick_rise_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        sync_q[0] <= 1'b0;
                    else
                        sync_q[0] <= tick_async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        sync_q[s] <= 1'b0;
                    else
                        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= 1'b0;
        else
            last_q <= sync_q[SYNC_STAGES-1];
    end

    always_comb tick_rise_o = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/wdog_unlock_fsm.sv
module wdog_unlock_fsm
    import wdog_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic open_o
);

    localparam int WIN_W = $clog2(WIN_CYC + 1);

    unl_state_e       state_q, state_d;
    logic [WIN_W-1:0] left_q, left_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UNL_LOCKED;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            UNL_LOCKED: begin
                if (arm_i) begin
                    state_d = UNL_OPEN;
                    left_d  = WIN_W'(WIN_CYC);
                end
            end
            UNL_OPEN: begin
                if (arm_i) begin
                    left_d = WIN_W'(WIN_CYC);
                end else if (left_q == WIN_W'(1)) begin
                    state_d = UNL_LOCKED;
                    left_d  = '0;
                end else begin
                    left_d = left_q - WIN_W'(1);
                end
            end
            default: begin
                state_d = UNL_LOCKED;
                left_d  = '0;
            end
        endcase
    end

    always_comb open_o = (state_q == UNL_OPEN);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            kick_i,
    input  logic            tick_rise_i,
    input  logic [PS_W-1:0] ps_sel_i,
    output logic            req_o
);

    localparam int CNT_W = BASE_EXP + (1 << PS_W) - 1;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] term_cnt;
    logic [CNT_W-1:0] adv_cnt;
    logic             hit;

    // Shifting out of range yields zero, and minus one then gives the all-ones limit.
    always_comb term_cnt = (CNT_W'(1) << (BASE_EXP + int'(ps_sel_i))) - CNT_W'(1);

    always_comb begin
        hit     = 1'b0;
        adv_cnt = cnt_q;
        if (kick_i) begin
            adv_cnt = '0;
        end else if (tick_rise_i) begin
            if (cnt_q >= term_cnt) begin
                adv_cnt = '0;
                hit     = 1'b1;
            end else begin
                adv_cnt = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CT_IDLE: begin
                if (en_i) begin
                    state_d = hit ? CT_FIRE : CT_COUNT;
                    cnt_d   = adv_cnt;
                end else begin
                    cnt_d = '0;
                end
            end
            CT_COUNT, CT_FIRE: begin
                if (!en_i) begin
                    state_d = CT_IDLE;
                    cnt_d   = '0;
                end else begin
                    state_d = hit ? CT_FIRE : CT_COUNT;
                    cnt_d   = adv_cnt;
                end
            end
            default: begin
                state_d = CT_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb req_o = (state_q == CT_FIRE);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int BASE_EXP    = 14,
    parameter int WIN_CYC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_a_i,
    input  logic             cfg_b_i,
    input  logic             ctl_wr_i,
    input  logic [CTL_W-1:0] ctl_wd_i,
    output logic [CTL_W-1:0] ctl_rd_o,
    input  logic             kick_i,
    input  logic             tick_i,
    output logic             wdt_req_o
);

    safety_lvl_e     lvl_q;
    logic            en_q;
    logic [PS_W-1:0] ps_q;
    logic            win_open;
    logic            en_eff;
    logic            tick_rise;
    ctl_cmd_t        cmd;

    // Write decode: the window state seen here is the one before this write.
    always_comb begin
        cmd.arm     = ctl_wr_i & ctl_wd_i[CE_POS];
        cmd.en_set  = ctl_wr_i & ctl_wd_i[EN_POS] & (lvl_q != LVL_2);
        cmd.en_clr  = ctl_wr_i & ~ctl_wd_i[EN_POS] & win_open & (lvl_q != LVL_2);
        cmd.ps_load = ctl_wr_i & ((lvl_q == LVL_0) | win_open);
        cmd.ps_val  = ctl_wd_i[PS_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= strap_level(cfg_a_i, cfg_b_i);
            en_q  <= 1'b0;
            ps_q  <= '0;
        end else begin
            if (cmd.en_set)
                en_q <= 1'b1;
            else if (cmd.en_clr)
                en_q <= 1'b0;
            if (cmd.ps_load)
                ps_q <= cmd.ps_val;
        end
    end

    always_comb en_eff = en_q | (lvl_q == LVL_2);

    wdog_unlock_fsm #(
        .WIN_CYC (WIN_CYC)
    ) u_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (cmd.arm),
        .open_o (win_open)
    );

    wdog_tick_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_async_i (tick_i),
        .tick_rise_o  (tick_rise)
    );

    wdog_counter #(
        .BASE_EXP (BASE_EXP)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_eff),
        .kick_i      (kick_i),
        .tick_rise_i (tick_rise),
        .ps_sel_i    (ps_q),
        .req_o       (wdt_req_o)
    );

    always_comb ctl_rd_o = {{RESV_W{1'b0}}, win_open, en_eff, ps_q};

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_a_i,
    input logic       cfg_b_i,
    input logic       ctl_wr_i,
    input logic [7:0] ctl_wd_i,
    input logic [7:0] ctl_rd_o,
    input logic       wdt_req_o
);

    logic       lvl2_q;
    logic       lvl0_q;
    logic [2:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl2_q <= cfg_b_i;
            lvl0_q <= cfg_a_i & ~cfg_b_i;
            age_q  <= 3'd7;
        end else if (ctl_wr_i && ctl_wd_i[4]) begin
            age_q <= 3'd0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 3'd1;
        end
    end

    p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_o[7:5] == 3'b000);

    p_ce_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_o[4] == (age_q < 3'd4));

    p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_rd_o[3]) && !$past(ctl_rd_o[4])) |-> ctl_rd_o[3]);

    p_ps_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl0_q && !$past(ctl_rd_o[4])) |-> ctl_rd_o[2:0] == $past(ctl_rd_o[2:0]));

    p_lvl2_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lvl2_q |-> ctl_rd_o[3]);

    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req_o |=> !wdt_req_o);

    p_req_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req_o |-> $past(ctl_rd_o[3]));

endmodule

bind wdog_timer wdog_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_a_i   (cfg_a_i),
    .cfg_b_i   (cfg_b_i),
    .ctl_wr_i  (ctl_wr_i),
    .ctl_wd_i  (ctl_wd_i),
    .ctl_rd_o  (ctl_rd_o),
    .wdt_req_o (wdt_req_o)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 2;
    localparam int WIN        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_a = 1'b0, cfg_b = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rd;
    logic       kick = 1'b0, tick = 1'b0;
    logic       req;

    int compared = 0, mismatched = 0, cyc = 0, req_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_timer #(.BASE_EXP(BASE), .WIN_CYC(WIN), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_a_i(cfg_a), .cfg_b_i(cfg_b),
        .ctl_wr_i(wr), .ctl_wd_i(wd), .ctl_rd_o(rd),
        .kick_i(kick), .tick_i(tick), .wdt_req_o(req));

    // Behavioural reference model
    int   m_lvl = 1, m_win = 0, m_wdp = 0, m_cnt = 0;
    bit   m_wde = 0, m_req = 0, m_live = 0;
    bit   m_t1 = 0, m_t2 = 0, m_t3 = 0;

    always @(posedge clk) begin
        bit en, ce, rise;
        int lim;
        if (!rst_n) begin
            m_lvl = cfg_b ? 2 : (cfg_a ? 0 : 1);
            m_win = 0; m_wde = 0; m_wdp = 0; m_cnt = 0; m_req = 0;
            m_t1 = 0; m_t2 = 0; m_t3 = 0; m_live = 0;
        end else begin
            en   = (m_lvl == 2) || m_wde;
            ce   = (m_win > 0);
            rise = m_t2 && !m_t3;
            lim  = 1 << (BASE + m_wdp);
            m_req = 0;
            if (!en) m_cnt = 0;
            else if (kick) m_cnt = 0;
            else if (rise) begin
                if (m_cnt + 1 >= lim) begin m_cnt = 0; m_req = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (wr) begin
                if (m_lvl != 2) begin
                    if (wd[3]) m_wde = 1;
                    else if (ce) m_wde = 0;
                end
                if (m_lvl == 0 || ce) m_wdp = int'(wd[2:0]);
            end
            if (wr && wd[4]) m_win = WIN;
            else if (m_win > 0) m_win = m_win - 1;
            m_t3 = m_t2; m_t2 = m_t1; m_t1 = tick;
            m_live = 1;
        end
    end

    function automatic logic [7:0] model_rd();
        bit en = (m_lvl == 2) || m_wde;
        return {3'b000, (m_win > 0), en, 3'(m_wdp)};
    endfunction

    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (rst_n && m_live) begin
            exp_rd = model_rd();
            compared++;
            if (rd !== exp_rd || req !== m_req) begin
                mismatched++;
                if (rd[7:5] !== exp_rd[7:5])
                    $display("FAIL R2 cyc %0d reserved act %b exp %b", cyc, rd[7:5], exp_rd[7:5]);
                else if (rd[4] !== exp_rd[4])
                    $display("FAIL R3 cyc %0d change-enable act %b exp %b", cyc, rd[4], exp_rd[4]);
                else if (rd[3] !== exp_rd[3])
                    $display("FAIL R5 cyc %0d enable act %b exp %b", cyc, rd[3], exp_rd[3]);
                else if (rd[2:0] !== exp_rd[2:0])
                    $display("FAIL R6 cyc %0d prescaler act %0d exp %0d", cyc, rd[2:0], exp_rd[2:0]);
                else
                    $display("FAIL R9 cyc %0d request act %b exp %b", cyc, req, m_req);
            end
            if (req) req_seen++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s act 0x%0h exp 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic a, input logic b);
        @(negedge clk);
        rst_n = 1'b0; cfg_a = a; cfg_b = b; wr = 0; kick = 0; tick = 0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        wr = 1'b1; wd = d;
        @(negedge clk);
        wr = 1'b0; wd = 8'h00;
    endtask

    task automatic pulse(input int hi);
        tick = 1'b1; idle(hi);
        tick = 1'b0; idle(3);
    endtask

    task automatic do_kick();
        kick = 1'b1; @(negedge clk); kick = 1'b0;
    endtask

    initial begin : stim
        int base_req;
        // Level 1: straps low
        do_reset(1'b0, 1'b0);
        check(rd == 8'h00 && !req, "R1 reset level 1", rd, 8'h00);
        wr_ctl(8'h08);
        check(rd == 8'h08, "R4 enable set", rd, 8'h08);
        wr_ctl(8'hE2);
        check(rd == 8'h08, "R5/R6/R2 locked write ignored", rd, 8'h08);
        base_req = req_seen;
        repeat (3) pulse(3);
        check(req_seen == base_req, "R9 no request before period", req_seen, base_req);
        pulse(3); idle(4);
        check(req_seen == base_req + 1, "R9 request after 4 edges", req_seen, base_req + 1);
        repeat (3) pulse(3);
        do_kick();
        repeat (3) pulse(3); idle(4);
        check(req_seen == base_req + 1, "R10 kick restarts count", req_seen, base_req + 1);
        do_kick();
        pulse(25); pulse(25); pulse(3); idle(4);
        check(req_seen == base_req + 1, "R11 long pulses count once each", req_seen, base_req + 1);
        pulse(3); idle(4);
        check(req_seen == base_req + 2, "R11 fourth edge fires", req_seen, base_req + 2);
        wr_ctl(8'h18);
        wr_ctl(8'h01);
        check(rd == 8'h11, "R5/R6 unlocked clear and load", rd, 8'h11);
        idle(4);
        check(rd == 8'h01, "R3 window closed", rd, 8'h01);
        base_req = req_seen;
        repeat (10) pulse(3); idle(4);
        check(req_seen == base_req, "R10 disabled never fires", req_seen, base_req);

        // Level 0: strap A only
        do_reset(1'b1, 1'b0);
        check(rd == 8'h00, "R1/R7 reset level 0", rd, 8'h00);
        wr_ctl(8'h0B);
        check(rd == 8'h0B, "R6 free prescaler load", rd, 8'h0B);
        wr_ctl(8'h00);
        check(rd == 8'h08, "R5 clear without window ignored", rd, 8'h08);
        wr_ctl(8'h18);
        idle(2);
        check(rd[4] == 1'b1, "R3 window open", rd[4], 1);
        wr_ctl(8'h18);
        idle(3);
        check(rd[4] == 1'b1, "R3 re-armed window still open", rd[4], 1);
        idle(1);
        check(rd[4] == 1'b0, "R3 re-armed window closed", rd[4], 0);
        base_req = req_seen;
        repeat (4) pulse(3); idle(4);
        check(req_seen == base_req + 1, "R9 level 0 timeout", req_seen, base_req + 1);

        // Level 2: strap B only
        do_reset(1'b0, 1'b1);
        check(rd == 8'h08, "R1/R7 reset level 2", rd, 8'h08);
        wr_ctl(8'h18);
        wr_ctl(8'h00);
        check(rd[3] == 1'b1, "R8 cannot disable", rd[3], 1);
        wr_ctl(8'h10);
        wr_ctl(8'h02);
        check(rd[2:0] == 3'd2, "R6 level 2 unlocked load", rd[2:0], 2);
        idle(6);
        wr_ctl(8'h05);
        check(rd == 8'h0A, "R6 level 2 locked load ignored", rd, 8'h0A);

        // Both straps
        do_reset(1'b1, 1'b1);
        check(rd == 8'h08, "R7 both straps give level 2", rd, 8'h08);
        wr_ctl(8'h00);
        check(rd[3] == 1'b1, "R8 both straps stay enabled", rd[3], 1);

        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            mismatched++;
            $display("FAIL watchdog expired at cycle %0d act running exp finished", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule